// File: doc/BRIEF.md
# Segmented RAM write request adapter

This block turns byte-oriented write requests into single-beat writes on a wide RAM write port. The port is split into eight independent 128-bit segments. Each request carries a byte address, a byte count, a tag and up to 128 payload bytes. Requests wait in a small in-order queue, and the block issues them one at a time.

For each issued request, the block shifts the payload to its byte offset within the 1024-bit line. It raises one byte enable per written byte and one valid bit per segment that the span touches. It also writes the 12-bit line address into every segment's address slot.

The block holds the beat until the RAM raises ready. In that cycle it reports completion with the request's tag, and it may issue the next queued request on the following edge. A request that would spill past the end of its line is dropped and flagged instead of being issued. A request with zero length is handled the same way.

Top module: `seg_wr_adapter`

## Requirements
- R1: The queue holds up to FIFO_DEPTH waiting requests (default 4), and `req_ready_o` is low while it is full. A request is taken on a rising clock edge where `req_valid_i` and `req_ready_o` are both high. Requests are issued and completed strictly in the order they were taken.
- R2: Payload byte i (bits 8i+7..8i of `req_data_i`) appears at line byte off+i of `ram_data_o`, where off = address mod 128. Line byte k occupies bits 8k+7..8k. Line bytes outside the span are driven as zero.
- R3: `ram_be_o` bit k is set exactly for off <= k < off+len.
- R4: `ram_valid_o` bit s is set exactly when the span contains at least one byte in the range 16s..16s+15.
- R5: The line address is (address / 128) mod 4096. It is placed in every segment field, and segment j occupies bits 12j+11..12j of `ram_addr_o`.
- R6: While a write is outstanding and `ram_ready_i` is low, the data, enable, valid and address outputs hold their values.
- R7: In a cycle where a write is outstanding and `ram_ready_i` is high, `done_o` is high and `done_tag_o` carries that request's tag. If nothing is queued, valids and enables are all zero from the next cycle on.
- R8: When ready is accepted and another request is queued, the next request appears on the RAM port in the very next cycle, with no idle cycle in between.
- R9: A request whose length is zero or exceeds 128 - off is never presented to the RAM. Instead `err_o` pulses for exactly one cycle with `err_tag_o` set to its tag, and no `done_o` occurs for it.
- R10: After reset, all RAM outputs, `done_o` and `err_o` are zero and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Queue has room |
| req_addr_i | input | 32 | Byte address |
| req_len_i | input | 8 | Byte count |
| req_tag_i | input | 4 | Request tag |
| req_data_i | input | 1024 | Payload, byte i at bits 8i+7..8i |
| ram_addr_o | output | 96 | Eight 12-bit segment addresses |
| ram_data_o | output | 1024 | Line data |
| ram_be_o | output | 128 | Byte enables |
| ram_valid_o | output | 8 | Segment valids |
| ram_ready_i | input | 1 | RAM accepts the outstanding beat |
| done_o | output | 1 | Completion pulse |
| done_tag_o | output | 4 | Tag of the completed request |
| err_o | output | 1 | Rejection pulse |
| err_tag_o | output | 4 | Tag of the rejected request |

## Verification
Two functions can fall in the same cycle: the completion of one write and the issue of the next. A third case is completion together with the rejection of the next queued entry. The bench provokes both by filling the queue while `ram_ready_i` is held low, then holding ready high so that every cycle both completes a write and pops the next entry. It judges the result by requiring a `done_o` pulse with the expected tag in every consecutive cycle. It also requires the next request's address, enables and data to be present in that same cycle without a gap. A rejected entry must be skipped silently on the RAM side and flagged only on `err_o`.

// File: rtl/seg_wr_pkg.sv
package seg_wr_pkg;
  localparam int unsigned LINE_BYTES_DEF = 128;
  localparam int unsigned SEG_NUM_DEF    = 8;
  localparam int unsigned SEG_AW_DEF     = 12;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } wr_state_e;
endpackage

// File: rtl/seg_wr_fifo.sv
module seg_wr_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r1_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r1_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/seg_wr_lane_map.sv
module seg_wr_lane_map #(
  parameter int unsigned LINE_BYTES = 128,
  parameter int unsigned SEG_NUM    = 8,
  parameter int unsigned SEG_AW     = 12,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 8
) (
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LEN_W-1:0]          len_i,
  input  logic [LINE_BYTES*8-1:0]   data_i,
  output logic [LINE_BYTES*8-1:0]   data_o,
  output logic [LINE_BYTES-1:0]     be_o,
  output logic [SEG_NUM-1:0]        valid_o,
  output logic [SEG_NUM*SEG_AW-1:0] addr_o,
  output logic                      bad_o
);
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES);
  localparam int unsigned SEG_BYTES = LINE_BYTES / SEG_NUM;
  localparam int unsigned SPAN_W    = ((OFF_W > LEN_W) ? OFF_W : LEN_W) + 1;
  localparam int unsigned DW        = LINE_BYTES * 8;

  logic [OFF_W-1:0]  off;
  logic [SEG_AW-1:0] line;
  logic [SPAN_W-1:0] end_pos;
  logic [DW-1:0]     shifted;

  assign off     = addr_i[OFF_W-1:0];
  assign line    = addr_i[OFF_W +: SEG_AW];
  assign end_pos = SPAN_W'(off) + SPAN_W'(len_i);
  assign bad_o   = (len_i == '0) || (end_pos > SPAN_W'(LINE_BYTES));
  assign shifted = data_i << {off, 3'b000};

  always_comb begin
    for (int k = 0; k < LINE_BYTES; k++) begin
      be_o[k] = (SPAN_W'(k) >= SPAN_W'(off)) && (SPAN_W'(k) < end_pos);
      data_o[k*8 +: 8] = be_o[k] ? shifted[k*8 +: 8] : 8'h00;
    end
  end

  for (genvar s = 0; s < SEG_NUM; s++) begin : g_seg
    assign valid_o[s]                = |be_o[s*SEG_BYTES +: SEG_BYTES];
    assign addr_o[s*SEG_AW +: SEG_AW] = line;
  end
endmodule

// File: rtl/seg_wr_adapter.sv
module seg_wr_adapter
  import seg_wr_pkg::*;
#(
  parameter int unsigned LINE_BYTES = LINE_BYTES_DEF,
  parameter int unsigned SEG_NUM    = SEG_NUM_DEF,
  parameter int unsigned SEG_AW     = SEG_AW_DEF,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned TAG_W      = 4,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic [LEN_W-1:0]          req_len_i,
  input  logic [TAG_W-1:0]          req_tag_i,
  input  logic [LINE_BYTES*8-1:0]   req_data_i,
  output logic [SEG_NUM*SEG_AW-1:0] ram_addr_o,
  output logic [LINE_BYTES*8-1:0]   ram_data_o,
  output logic [LINE_BYTES-1:0]     ram_be_o,
  output logic [SEG_NUM-1:0]        ram_valid_o,
  input  logic                      ram_ready_i,
  output logic                      done_o,
  output logic [TAG_W-1:0]          done_tag_o,
  output logic                      err_o,
  output logic [TAG_W-1:0]          err_tag_o
);
  localparam int unsigned DW = LINE_BYTES * 8;
  localparam int unsigned EW = TAG_W + LEN_W + ADDR_W + DW;

  logic [EW-1:0]             q_din, q_dout;
  logic                      q_full, q_empty, q_push, q_pop;
  logic [TAG_W-1:0]          h_tag;
  logic [LEN_W-1:0]          h_len;
  logic [ADDR_W-1:0]         h_addr;
  logic [DW-1:0]             h_data;
  logic [DW-1:0]             m_data;
  logic [LINE_BYTES-1:0]     m_be;
  logic [SEG_NUM-1:0]        m_valid;
  logic [SEG_NUM*SEG_AW-1:0] m_addr;
  logic                      m_bad;
  wr_state_e                 st_q;
  logic [TAG_W-1:0]          cur_tag_q;
  logic                      accept;

  assign q_din       = {req_tag_i, req_len_i, req_addr_i, req_data_i};
  assign q_push      = req_valid_i & ~q_full;
  assign req_ready_o = ~q_full;
  assign {h_tag, h_len, h_addr, h_data} = q_dout;

  seg_wr_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (q_push),
    .din_i  (q_din),
    .pop_i  (q_pop),
    .dout_o (q_dout),
    .full_o (q_full),
    .empty_o(q_empty)
  );

  seg_wr_lane_map #(
    .LINE_BYTES(LINE_BYTES), .SEG_NUM(SEG_NUM), .SEG_AW(SEG_AW),
    .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) u_map (
    .addr_i (h_addr),
    .len_i  (h_len),
    .data_i (h_data),
    .data_o (m_data),
    .be_o   (m_be),
    .valid_o(m_valid),
    .addr_o (m_addr),
    .bad_o  (m_bad)
  );

  // completion and next issue share the same edge
  assign accept     = (st_q == ST_BUSY) & ram_ready_i;
  assign q_pop      = ~q_empty & ((st_q == ST_IDLE) | ram_ready_i);
  assign done_o     = accept;
  assign done_tag_o = cur_tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cur_tag_q   <= '0;
      ram_addr_o  <= '0;
      ram_data_o  <= '0;
      ram_be_o    <= '0;
      ram_valid_o <= '0;
      err_o       <= 1'b0;
      err_tag_o   <= '0;
    end else begin
      err_o <= 1'b0;
      if (accept) begin
        st_q        <= ST_IDLE;
        ram_be_o    <= '0;
        ram_valid_o <= '0;
      end
      if (q_pop) begin
        if (m_bad) begin
          err_o     <= 1'b1;
          err_tag_o <= h_tag;
        end else begin
          st_q        <= ST_BUSY;
          cur_tag_q   <= h_tag;
          ram_addr_o  <= m_addr;
          ram_data_o  <= m_data;
          ram_be_o    <= m_be;
          ram_valid_o <= m_valid;
        end
      end
    end
  end

  a_r6_hold_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BUSY && !ram_ready_i) |=>
      ($stable(ram_be_o) && $stable(ram_valid_o) && $stable(ram_data_o) && $stable(ram_addr_o)));
  a_r7_done_has_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ram_valid_o != '0));
  a_r7_clear_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && q_empty) |=> (ram_valid_o == '0 && ram_be_o == '0));
  a_r9_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ram_valid_o == '0 && !done_o));
  a_r4_valid_with_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_valid_o == '0) == (ram_be_o == '0));
endmodule

// File: tb/tb_seg_wr_adapter.sv
module tb_seg_wr_adapter;
  localparam int CLK_PERIOD = 10;
  localparam int SEED = 32'h5eed_0017;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [31:0]   req_addr = '0;
  logic [7:0]    req_len = '0;
  logic [3:0]    req_tag = '0;
  logic [1023:0] req_data = '0;
  logic [95:0]   ram_addr;
  logic [1023:0] ram_data;
  logic [127:0]  ram_be;
  logic [7:0]    ram_valid;
  logic          ram_ready = 1'b0;
  logic          done;
  logic [3:0]    done_tag;
  logic          err;
  logic [3:0]    err_tag;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_wr_adapter dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_tag_i(req_tag), .req_data_i(req_data),
    .ram_addr_o(ram_addr), .ram_data_o(ram_data), .ram_be_o(ram_be), .ram_valid_o(ram_valid),
    .ram_ready_i(ram_ready),
    .done_o(done), .done_tag_o(done_tag), .err_o(err), .err_tag_o(err_tag)
  );

  task automatic chk(input bit ok, input string req, input logic [1023:0] act, input logic [1023:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_be(input int off, input int len);
    logic [127:0] b = '0;
    for (int k = 0; k < 128; k++) b[k] = (k >= off) && (k < off + len);
    return b;
  endfunction

  function automatic logic [7:0] exp_valid(input int off, input int len);
    logic [7:0] v = '0;
    for (int k = off; k < off + len; k++) v[k/16] = 1'b1;
    return v;
  endfunction

  function automatic logic [1023:0] exp_data(input int off, input int len, input logic [1023:0] d);
    logic [1023:0] r = '0;
    for (int k = off; k < off + len; k++) r[k*8 +: 8] = d[(k-off)*8 +: 8];
    return r;
  endfunction

  function automatic logic [95:0] exp_addr(input logic [31:0] a);
    logic [95:0] r;
    for (int j = 0; j < 8; j++) r[j*12 +: 12] = a[18:7];
    return r;
  endfunction

  function automatic logic [1023:0] rand_data();
    logic [1023:0] d;
    for (int w = 0; w < 32; w++) d[w*32 +: 32] = $urandom;
    return d;
  endfunction

  // drive one request at a negedge; returns at the following negedge
  task automatic send(input logic [31:0] a, input logic [7:0] l, input logic [3:0] t, input logic [1023:0] d);
    req_valid = 1'b1; req_addr = a; req_len = l; req_tag = t; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_beat(input logic [31:0] a, input int len, input logic [1023:0] d, input string tagname);
    int off = int'(a[6:0]);
    chk(ram_data == exp_data(off, len, d), {"R2 data ", tagname}, ram_data, exp_data(off, len, d));
    chk(ram_be == exp_be(off, len), {"R3 be ", tagname}, ram_be, exp_be(off, len));
    chk(ram_valid == exp_valid(off, len), {"R4 valid ", tagname}, ram_valid, exp_valid(off, len));
    chk(ram_addr == exp_addr(a), {"R5 addr ", tagname}, ram_addr, exp_addr(a));
  endtask

  // single request: good ones are checked, held, then completed; bad ones must flag
  task automatic one_req(input logic [31:0] a, input logic [7:0] l, input logic [3:0] t, input int hold);
    logic [1023:0] d = rand_data();
    int off = int'(a[6:0]);
    bit bad = (l == 0) || (int'(l) > 128 - off);
    send(a, l, t, d);
    @(negedge clk);
    if (bad) begin
      chk(err === 1'b1, "R9 err pulse", 1024'(err), 1);
      chk(err_tag == t, "R9 err tag", 1024'(err_tag), 1024'(t));
      chk(ram_valid == 8'h00 && ram_be == '0, "R9 ram untouched", 1024'(ram_valid), 0);
      chk(done === 1'b0, "R9 no done", 1024'(done), 0);
      @(negedge clk);
      chk(err === 1'b0, "R9 single pulse", 1024'(err), 0);
      chk(ram_valid == 8'h00, "R9 ram still idle", 1024'(ram_valid), 0);
    end else begin
      check_beat(a, int'(l), d, "issue");
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(done === 1'b0, "R6 no done while ready low", 1024'(done), 0);
        check_beat(a, int'(l), d, "R6 hold");
      end
      ram_ready = 1'b1;
      #1;
      chk(done === 1'b1, "R7 done pulse", 1024'(done), 1);
      chk(done_tag == t, "R7 done tag", 1024'(done_tag), 1024'(t));
      @(negedge clk);
      ram_ready = 1'b0;
      chk(ram_valid == 8'h00 && ram_be == '0, "R7 cleared after done", 1024'(ram_be), 0);
      chk(done === 1'b0, "R7 done one cycle", 1024'(done), 0);
    end
  endtask

  logic [31:0]   fa [5];
  logic [7:0]    fl [5];
  logic [1023:0] fd [5];

  initial begin
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(ram_valid == 8'h00 && ram_be == '0 && ram_data == '0 && ram_addr == '0, "R10 ram outputs zero", 1024'(ram_valid), 0);
    chk(done === 1'b0 && err === 1'b0, "R10 pulses low", 1024'({done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R10 ready after reset", 1024'(req_ready), 1);

    // directed corners
    one_req(32'h0003_0000, 8'd128, 4'h1, 1);   // full line, all segments
    one_req(32'h0001_2F7F, 8'd1,   4'h2, 2);   // last byte, segment 7 only
    one_req(32'h0000_008F, 8'd2,   4'h3, 0);   // straddles segments 0 and 1
    one_req(32'h0000_0078, 8'd9,   4'h4, 0);   // one past line end
    one_req(32'h0000_0100, 8'd0,   4'h5, 0);   // zero length
    one_req(32'h0000_0000, 8'd129, 4'h6, 0);   // longer than a line
    one_req(32'hFFFF_FF80, 8'd255, 4'h7, 0);   // max length

    // R1 fill + R8 back-to-back drain
    for (int i = 0; i < 5; i++) begin
      fa[i] = {$urandom} & 32'hFFFF_FFF0;
      fl[i] = 8'd16;
      fd[i] = rand_data();
      send(fa[i], fl[i], 4'(8 + i), fd[i]);
    end
    chk(req_ready === 1'b0, "R1 ready low when full", 1024'(req_ready), 0);
    check_beat(fa[0], 16, fd[0], "R1 head");
    ram_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1;
      chk(done === 1'b1 && done_tag == 4'(8 + i), "R8 R1 back-to-back done order", 1024'(done_tag), 1024'(8 + i));
      check_beat(fa[i], 16, fd[i], "R8 consecutive");
      @(negedge clk);
    end
    ram_ready = 1'b0;
    chk(ram_valid == 8'h00, "R7 idle after drain", 1024'(ram_valid), 0);

    // completion together with a rejected next entry
    send(32'h0000_0200, 8'd4, 4'hA, rand_data());
    send(32'h0000_027F, 8'd3, 4'hB, rand_data());
    ram_ready = 1'b1;
    #1;
    chk(done === 1'b1 && done_tag == 4'hA, "R7 done before reject", 1024'(done_tag), 10);
    @(negedge clk);
    ram_ready = 1'b0;
    chk(err === 1'b1 && err_tag == 4'hB, "R9 reject after done", 1024'(err_tag), 11);
    chk(ram_valid == 8'h00, "R9 no beat for rejected", 1024'(ram_valid), 0);
    @(negedge clk);

    // constrained random
    for (int n = 0; n < 60; n++) begin
      logic [31:0] a = $urandom;
      int off = int'(a[6:0]);
      int l;
      int sel = $urandom % 6;
      if (sel == 0) l = 129 - off + ($urandom % (127 + off));
      else if (sel == 1 && n % 3 == 0) l = 0;
      else l = 1 + ($urandom % (128 - off));
      if (l > 255) l = 255;
      one_req(a, 8'(l), 4'(n), $urandom % 3);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule